// File: doc/BRIEF.md
# Transceiver Reset Handshake Sequencer

This block brings a transceiver tile out of reset through two request/acknowledge pairs, one for the transmit side and one for the receive side. Each pair uses active-low signals. For each side, the block pulls the reset request low and waits for the tile to pull the acknowledge low. A sticky latch captures that acknowledge. The latch, not the live acknowledge, lets the request go high again. The block then waits for the acknowledge to return high, which closes the handshake for that side.

The two sides never run at the same time. The transmit handshake finishes completely before the receive request is asserted, which gives an internal serial loopback a transmitter to lock onto. The sequence starts once the PLL-locked input is high. If lock is lost at any point, both requests are released and the sequence starts again from the beginning when lock returns.

A programmable timeout guards every wait step. If a step waits too long, the block raises a sticky error, releases both requests, returns to idle and does not retry. Only a loss of lock clears the error. After both handshakes complete, a done flag stays high.

Top module: `tile_rst_seq`

## Requirements
- R1: During and right after the asynchronous reset, `tx_rst_n` and `rx_rst_n` are 1 and `done` and `error` are 0.
- R2: While `pll_locked` is 0, both reset requests stay 1 and `done` stays 0.
- R3: When `pll_locked` is high in idle with no error, `tx_rst_n` goes to 0 on the next clock edge. It stays 0 until `tx_ack_n` has been sampled 0.
- R4: The acknowledge is held in a sticky latch. An acknowledge that is low for only one cycle still releases the request (1) and lets the handshake finish.
- R5: `rx_rst_n` goes low only after the transmit handshake is complete, meaning `tx_ack_n` has returned to 1 after `tx_rst_n` was released.
- R6: The receive side follows the same hold, latch, release and idle-return handshake on `rx_rst_n`/`rx_ack_n`.
- R7: `done` rises once both handshakes are complete. It stays 1, with both requests at 1, for as long as `pll_locked` stays high.
- R8: When `pll_locked` falls, both requests go to 1 and `done` goes to 0 on the next edge. A full sequence runs again when lock returns.
- R9: If a wait step lasts `timeout_limit` cycles, `error` goes to 1 and both requests go to 1 on the same edge. No new sequence starts while `error` is 1. `error` clears when `pll_locked` is 0.
- R10: A tile that answers each step within fewer than `timeout_limit` cycles completes the sequence without setting `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pll_locked | input | 1 | Start qualifier; a low level aborts and re-arms the sequence |
| timeout_limit | input | CNT_W | Maximum number of cycles allowed in one wait step |
| tx_ack_n | input | 1 | Transmit reset acknowledge from the tile, active low |
| rx_ack_n | input | 1 | Receive reset acknowledge from the tile, active low |
| tx_rst_n | output | 1 | Transmit reset request to the tile, active low |
| rx_rst_n | output | 1 | Receive reset request to the tile, active low |
| done | output | 1 | Both handshakes complete |
| error | output | 1 | Sticky timeout flag |

## Verification
Each fault inside the block shows up at the ports within a few cycles as a change in the order or timing of edges on the four outputs. A lost sticky latch leaves `tx_rst_n` low after a one-cycle acknowledge until the timeout fires, roughly `timeout_limit` cycles later. A wrong phase transition lets `rx_rst_n` fall before the transmit side closes, and the event scoreboard sees this on the very edge where it happens. A timer that never clears, or that counts wrongly, either sets `error` on a tile that answers in time or fails to set it on a tile that never answers.

// File: rtl/tile_rst_seq_pkg.sv
package tile_rst_seq_pkg;
  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned SIDE_TX   = 0;
  localparam int unsigned SIDE_RX   = 1;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_HOLD = 2'd1,
    HS_REL  = 2'd2,
    HS_DONE = 2'd3
  } hs_state_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_TX   = 2'd1,
    PH_RX   = 2'd2,
    PH_DONE = 2'd3
  } phase_e;
endpackage

// File: rtl/tile_rst_side.sv
module tile_rst_side
  import tile_rst_seq_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic clr_i,
  input  logic start_i,
  input  logic ack_n_i,
  output logic req_n_o,
  output logic waiting_o,
  output logic complete_o,
  output logic advance_o
);
  hs_state_e state_q, state_d;
  logic      sticky_q, sticky_d;
  logic      state_en, sticky_en;

  always_comb begin
    state_d  = state_q;
    sticky_d = sticky_q;
    if (clr_i) begin
      state_d  = HS_IDLE;
      sticky_d = 1'b0;
    end else begin
      case (state_q)
        HS_IDLE: if (start_i) begin
          state_d  = HS_HOLD;
          sticky_d = 1'b0;
        end
        HS_HOLD: begin
          if (!ack_n_i) sticky_d = 1'b1;
          if (sticky_q) state_d = HS_REL;
        end
        HS_REL:  if (ack_n_i) state_d = HS_DONE;
        default: state_d = state_q;
      endcase
    end
  end

  assign state_en  = (state_d != state_q);
  assign sticky_en = (sticky_d != sticky_q);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q  <= HS_IDLE;
      sticky_q <= 1'b0;
    end else begin
      if (state_en)  state_q  <= state_d;
      if (sticky_en) sticky_q <= sticky_d;
    end
  end

  assign req_n_o    = !((state_q == HS_HOLD) && !sticky_q);
  assign waiting_o  = (state_q == HS_HOLD) || (state_q == HS_REL);
  assign complete_o = (state_q == HS_DONE);
  assign advance_o  = state_en;

  // Request release only comes from the latched acknowledge or an abort.
  assert_release_by_latch_R3: assert property (@(posedge clk) disable iff (!arst_n)
    (req_n_o && !$past(req_n_o)) |-> (sticky_q || $past(clr_i)));

  // The latch keeps the acknowledge once captured.
  assert_latch_holds_R4: assert property (@(posedge clk) disable iff (!arst_n)
    (sticky_q && !clr_i && !start_i) |=> sticky_q);
endmodule

// File: rtl/tile_rst_timer.sv
module tile_rst_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    if (clear_i || !run_i)    cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    else                       cnt_d = cnt_q;
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = run_i && (cnt_q >= limit_i);
endmodule

// File: rtl/tile_rst_seq.sv
module tile_rst_seq
  import tile_rst_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_locked,
  input  logic [CNT_W-1:0] timeout_limit,
  input  logic             tx_ack_n,
  input  logic             rx_ack_n,
  output logic             tx_rst_n,
  output logic             rx_rst_n,
  output logic             done,
  output logic             error
);
  logic                 arst_q1, arst_q2;
  logic [NUM_SIDES-1:0] ack_n, req_n, start, waiting, complete, advance;
  logic                 clr, expired, tmr_run, tmr_clear;
  phase_e               ph_q, ph_d;
  logic                 err_q, err_d, ph_en, err_en;

  // Asynchronous assertion, synchronous release of the local reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arst_q1 <= 1'b0;
      arst_q2 <= 1'b0;
    end else begin
      arst_q1 <= 1'b1;
      arst_q2 <= arst_q1;
    end
  end

  assign ack_n[SIDE_TX] = tx_ack_n;
  assign ack_n[SIDE_RX] = rx_ack_n;
  assign clr            = !pll_locked || expired;

  assign start[SIDE_TX] = (ph_q == PH_IDLE) && pll_locked && !err_q;
  assign start[SIDE_RX] = (ph_q == PH_TX) && complete[SIDE_TX] && !clr;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    tile_rst_side u_side (
      .clk        (clk),
      .arst_n     (arst_q2),
      .clr_i      (clr),
      .start_i    (start[s]),
      .ack_n_i    (ack_n[s]),
      .req_n_o    (req_n[s]),
      .waiting_o  (waiting[s]),
      .complete_o (complete[s]),
      .advance_o  (advance[s])
    );
  end

  assign tmr_run   = ((ph_q == PH_TX) && waiting[SIDE_TX]) ||
                     ((ph_q == PH_RX) && waiting[SIDE_RX]);
  assign tmr_clear = |advance;

  tile_rst_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .arst_n    (arst_q2),
    .run_i     (tmr_run),
    .clear_i   (tmr_clear),
    .limit_i   (timeout_limit),
    .expired_o (expired)
  );

  always_comb begin
    ph_d  = ph_q;
    err_d = err_q;
    if (!pll_locked) begin
      ph_d  = PH_IDLE;
      err_d = 1'b0;
    end else if (expired) begin
      ph_d  = PH_IDLE;
      err_d = 1'b1;
    end else begin
      case (ph_q)
        PH_IDLE: if (start[SIDE_TX]) ph_d = PH_TX;
        PH_TX:   if (complete[SIDE_TX]) ph_d = PH_RX;
        PH_RX:   if (complete[SIDE_RX]) ph_d = PH_DONE;
        default: ph_d = ph_q;
      endcase
    end
  end

  assign ph_en  = (ph_d != ph_q);
  assign err_en = (err_d != err_q);

  always_ff @(posedge clk or negedge arst_q2) begin
    if (!arst_q2) begin
      ph_q  <= PH_IDLE;
      err_q <= 1'b0;
    end else begin
      if (ph_en)  ph_q  <= ph_d;
      if (err_en) err_q <= err_d;
    end
  end

  assign tx_rst_n = req_n[SIDE_TX];
  assign rx_rst_n = req_n[SIDE_RX];
  assign done     = (ph_q == PH_DONE);
  assign error    = err_q;

  assert_rx_after_tx_R5: assert property (@(posedge clk) disable iff (!arst_q2)
    !rx_rst_n |-> complete[SIDE_TX]);

  assert_done_released_R7: assert property (@(posedge clk) disable iff (!arst_q2)
    done |-> (tx_rst_n && rx_rst_n && !error));

  assert_error_idle_R9: assert property (@(posedge clk) disable iff (!arst_q2)
    error |-> (tx_rst_n && rx_rst_n && !done));

  assert_lock_loss_R8: assert property (@(posedge clk) disable iff (!arst_q2)
    !pll_locked |=> (tx_rst_n && rx_rst_n && !done));
endmodule

// File: tb/tile_rst_seq_bench.sv
`timescale 1ns/1ps
module tile_rst_seq_bench;
  localparam int CNT_W = 16;
  localparam int EV_TXF = 1, EV_TXR = 2, EV_RXF = 3, EV_RXR = 4,
                 EV_DNR = 5, EV_DNF = 6, EV_ERR = 7, EV_ERF = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             pll_locked;
  logic [CNT_W-1:0] timeout_limit;
  logic             tx_ack_n, rx_ack_n;
  logic             tx_rst_n, rx_rst_n, done, error;

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  int resp_delay = 3;
  bit pulse_mode = 1'b0;
  bit stuck_tx   = 1'b0;
  bit mon_on     = 1'b0;
  int cycles     = 0;

  always #2.5 clk = ~clk;

  tile_rst_seq #(.CNT_W(CNT_W)) u_tile_rst_seq (
    .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked),
    .timeout_limit(timeout_limit), .tx_ack_n(tx_ack_n), .rx_ack_n(rx_ack_n),
    .tx_rst_n(tx_rst_n), .rx_rst_n(rx_rst_n), .done(done), .error(error)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_ev(input int ev);
    exp_q.push_back(ev);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_done(input int max);
    for (int i = 0; i < max && !done; i++) @(negedge clk);
  endtask

  // Tile model: answers each request after resp_delay cycles.
  int cnt_tx = 0, cnt_rx = 0;
  initial begin
    tx_ack_n = 1'b1;
    rx_ack_n = 1'b1;
    forever begin
      @(negedge clk);
      if (!tx_ack_n) begin
        if (pulse_mode) tx_ack_n = 1'b1;
        else if (tx_rst_n) begin
          cnt_tx++;
          if (cnt_tx >= resp_delay) begin tx_ack_n = 1'b1; cnt_tx = 0; end
        end
      end else if (!tx_rst_n && !stuck_tx) begin
        cnt_tx++;
        if (cnt_tx >= resp_delay) begin tx_ack_n = 1'b0; cnt_tx = 0; end
      end else cnt_tx = 0;
      if (!rx_ack_n) begin
        if (pulse_mode) rx_ack_n = 1'b1;
        else if (rx_rst_n) begin
          cnt_rx++;
          if (cnt_rx >= resp_delay) begin rx_ack_n = 1'b1; cnt_rx = 0; end
        end
      end else if (!rx_rst_n) begin
        cnt_rx++;
        if (cnt_rx >= resp_delay) begin rx_ack_n = 1'b0; cnt_rx = 0; end
      end else cnt_rx = 0;
    end
  end

  // Monitor: turn output edges into events and compare with the queue.
  task automatic got_ev(input int ev);
    int e;
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R5/R7 order: actual=%0d expected=none", ev);
    end else begin
      e = exp_q.pop_front();
      check("R3/R5/R6/R8/R9 event order", ev, e);
    end
  endtask

  logic p_tx, p_rx, p_dn, p_er;
  initial begin
    wait (mon_on);
    @(negedge clk);
    p_tx = tx_rst_n; p_rx = rx_rst_n; p_dn = done; p_er = error;
    forever begin
      @(negedge clk);
      if (tx_rst_n !== p_tx) got_ev(tx_rst_n ? EV_TXR : EV_TXF);
      if (rx_rst_n !== p_rx) got_ev(rx_rst_n ? EV_RXR : EV_RXF);
      if (done !== p_dn)     got_ev(done ? EV_DNR : EV_DNF);
      if (error !== p_er)    got_ev(error ? EV_ERR : EV_ERF);
      p_tx = tx_rst_n; p_rx = rx_rst_n; p_dn = done; p_er = error;
    end
  end

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
        finish_run();
      end
    end
  end

  task automatic full_seq_expect;
    expect_ev(EV_TXF); expect_ev(EV_TXR);
    expect_ev(EV_RXF); expect_ev(EV_RXR); expect_ev(EV_DNR);
  endtask

  initial begin
    rst_n = 1'b0;
    pll_locked = 1'b0;
    timeout_limit = 16'd1000;
    cyc(3);
    check("R1 tx_rst_n in reset", tx_rst_n, 1);
    check("R1 done in reset", done, 0);
    rst_n = 1'b1;
    cyc(3);
    check("R1 rx_rst_n", rx_rst_n, 1);
    check("R1 error", error, 0);
    mon_on = 1'b1;

    // R2: nothing moves without lock
    cyc(30);
    check("R2 tx idle", tx_rst_n, 1);
    check("R2 done idle", done, 0);

    // R3 R5 R6 R7: normal sequence
    resp_delay = 6;
    full_seq_expect();
    pll_locked = 1'b1;
    cyc(2);
    check("R3 tx held low", tx_rst_n, 0);
    check("R5 rx still released", rx_rst_n, 1);
    wait_done(300);
    check("R7 done", done, 1);
    cyc(20);
    check("R7 done held", done, 1);
    check("R7 both released", tx_rst_n & rx_rst_n, 1);

    // R8: lock loss after done, then rerun
    expect_ev(EV_DNF);
    pll_locked = 1'b0;
    cyc(3);
    check("R8 done cleared", done, 0);
    resp_delay = 2;
    full_seq_expect();
    pll_locked = 1'b1;
    wait_done(300);
    check("R8 rerun done", done, 1);

    // R8: lock loss mid-sequence
    expect_ev(EV_DNF);
    pll_locked = 1'b0;
    cyc(5);
    resp_delay = 10;
    expect_ev(EV_TXF);
    pll_locked = 1'b1;
    cyc(4);
    check("R8 tx low before abort", tx_rst_n, 0);
    expect_ev(EV_TXR);
    pll_locked = 1'b0;
    cyc(2);
    check("R8 tx released on abort", tx_rst_n, 1);
    check("R8 rx untouched", rx_rst_n, 1);
    cyc(15);

    // R4: one-cycle acknowledge still completes
    pulse_mode = 1'b1;
    resp_delay = 3;
    timeout_limit = 16'd40;
    full_seq_expect();
    pll_locked = 1'b1;
    wait_done(300);
    check("R4 done after pulse ack", done, 1);
    check("R4 no timeout", error, 0);
    expect_ev(EV_DNF);
    pll_locked = 1'b0;
    pulse_mode = 1'b0;
    cyc(5);

    // R9: timeout on a silent tile
    timeout_limit = 16'd20;
    stuck_tx = 1'b1;
    expect_ev(EV_TXF); expect_ev(EV_TXR); expect_ev(EV_ERR);
    pll_locked = 1'b1;
    cyc(15);
    check("R9 no early error", error, 0);
    cyc(45);
    check("R9 error set", error, 1);
    check("R9 tx released", tx_rst_n, 1);
    cyc(40);
    check("R9 no retry", tx_rst_n, 1);
    stuck_tx = 1'b0;
    expect_ev(EV_ERF);
    pll_locked = 1'b0;
    cyc(3);
    check("R9 error cleared", error, 0);

    // R10: slow but in-time tile
    resp_delay = 15;
    full_seq_expect();
    pll_locked = 1'b1;
    wait_done(400);
    check("R10 done", done, 1);
    check("R10 no error", error, 0);
    cyc(5);
    check("R6/R7 all events seen", exp_q.size(), 0);
    finish_run();
  end
endmodule